// File: doc/BRIEF.md
# Programmable 16-bit Interval Timer with Interrupt

This block is a sixteen-bit up-counter driven through three word-wide registers: the live count, a control word and a compare value. Software selects where the count wraps, either at the compare value or after the all-ones value. It also selects which of those events pulse the interrupt line, and whether that pulse repeats on every event or is given only once per control-word write. Two sticky flags record a compare match and a rollover. Reading the control word returns these flags and then clears them.

The rate at which the counter advances depends on which of three copies of the block is built, chosen by the `UNIT_IDX` parameter. Copy 0 can follow an external pixel-rate strobe. Copy 1 can follow an external line-rate strobe. Copy 2 can divide the system clock by eight or halt entirely. Without such a selection every copy advances once per system clock. The strobes come from outside the block.

Top module: `prog_timer16`

## Requirements
- R1: After reset the count, the control word, the compare value and the irq output all read as zero.
- R2: With no source selection, the count rises by one on each clock; a write to address 0 loads the written 16-bit value in place of that cycle's increment.
- R3: With control bit 3 set, a count equal to the compare value (address 2) returns to zero on the next advance instead of incrementing.
- R4: With control bit 3 clear, the count rolls from 0xFFFF to 0 and this rollover pulses irq when control bit 5 is set.
- R5: With control bit 4 set, each advance taken from a count equal to the compare value pulses irq for one cycle, on every match while control bit 6 is set.
- R6: With control bit 6 clear, only the first qualifying event after a control-word write pulses irq; a new control-word write re-arms it.
- R7: Control bit 11 (compare match) and bit 12 (rollover) are sticky and clear right after a read of address 1 that returns them; bit 10 is set on either event and stays set until the next control-word write.
- R8: A write to the control word (address 1) zeroes the count; a write to the compare value leaves the count's progress untouched.
- R9: In copy 2, control bit 9 advances the count once every eight clocks, counted from the control-word write, and control bit 0 holds the count frozen.
- R10: Control bits 13 to 15 always read as zero, and writes to bits 10 to 15 are not stored.
- R11: With control bit 8 set, copy 1 advances only on cycles where `line_tick` is high, and copy 0 only on cycles where `pix_tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only on address 1) |
| reg_addr | input | 2 | 0 = count, 1 = control word, 2 = compare value |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pix_tick | input | 1 | Pixel-rate advance strobe (copy 0) |
| line_tick | input | 1 | Line-rate advance strobe (copy 1) |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The rollover path is the hardest state to reach from the ports, because a free run needs 65536 advances. The stimulus loads the count to 0xFFFD just after a control-word write and parks the compare value far away. The rollover, its interrupt pulse and the sticky flag then fall in a known cycle a few clocks later. Two back-to-back reads of the control word then show the flag present and then cleared. The one-shot check pairs a long run that contains several matches with a second control-word write. This shows both the suppression of later matches and the re-arming.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   localparam int unsigned CTRL_W = 10;

   typedef enum logic [1:0] {
      ADDR_COUNT  = 2'd0,
      ADDR_CTRL   = 2'd1,
      ADDR_CMP    = 2'd2,
      ADDR_UNUSED = 2'd3
   } reg_sel_e;

   // control word bit positions
   localparam int unsigned B_HALT     = 0;
   localparam int unsigned B_WRAP_CMP = 3;
   localparam int unsigned B_IE_CMP   = 4;
   localparam int unsigned B_IE_ROLL  = 5;
   localparam int unsigned B_REPEAT   = 6;
   localparam int unsigned B_SRC_EXT  = 8;
   localparam int unsigned B_SRC_DIV  = 9;
   localparam int unsigned B_ST_ANY   = 10;
   localparam int unsigned B_ST_CMP   = 11;
   localparam int unsigned B_ST_ROLL  = 12;

   typedef struct packed {
      logic any;
      logic cmp;
      logic roll;
   } ptmr_status_t;

endpackage

// File: rtl/ptmr_tick_sel.sv
module ptmr_tick_sel #(
   parameter int unsigned UNIT_IDX = 2,
   parameter int unsigned PRE_DIV  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic halt,
   input  logic src_ext,
   input  logic src_div,
   input  logic pix_tick,
   input  logic line_tick,
   output logic tick
);
   localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

   logic div_tick;

   if (PRE_DIV < 2) begin : g_bad_div
      $error("ptmr_tick_sel: PRE_DIV must be at least 2");
   end
   if (UNIT_IDX > 2) begin : g_bad_idx
      $error("ptmr_tick_sel: UNIT_IDX must be 0, 1 or 2");
   end

   if (UNIT_IDX == 2) begin : g_prescale
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
         if (!rst_n || restart) begin
            pre_q <= '0;
         end else if (pre_q == PW'(PRE_DIV - 1)) begin
            pre_q <= '0;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
      assign div_tick = (pre_q == PW'(PRE_DIV - 1));
   end else begin : g_no_prescale
      assign div_tick = 1'b0;
   end

   always_comb begin
      if (UNIT_IDX == 0) begin
         tick = src_ext ? pix_tick : 1'b1;
      end else if (UNIT_IDX == 1) begin
         tick = src_ext ? line_tick : 1'b1;
      end else begin
         tick = halt ? 1'b0 : (src_div ? div_tick : 1'b1);
      end
   end

endmodule

// File: rtl/ptmr_count_core.sv
module ptmr_count_core #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          tick,
   input  logic          wrap_cmp,
   input  logic [CW-1:0] cmp_val,
   output logic [CW-1:0] count,
   output logic          cmp_hit,
   output logic          roll_hit
);
   localparam logic [CW-1:0] ALL_ONES = '1;

   logic advance;
   logic at_cmp;
   logic at_top;
   logic [CW-1:0] cnt_q;

   assign advance  = tick && !clear && !load;
   assign at_cmp   = (cnt_q == cmp_val);
   assign at_top   = (cnt_q == ALL_ONES);
   assign cmp_hit  = advance && at_cmp;
   // a compare wrap takes priority over a rollover at the same value
   assign roll_hit = advance && at_top && !(wrap_cmp && at_cmp);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (advance) begin
         if (wrap_cmp && at_cmp) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign count = cnt_q;

endmodule

// File: rtl/ptmr_event_ctl.sv
module ptmr_event_ctl
   import ptmr_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ctrl_wr,
   input  logic         ctrl_rd,
   input  logic         cmp_hit,
   input  logic         roll_hit,
   input  logic         ie_cmp,
   input  logic         ie_roll,
   input  logic         repeat_en,
   output ptmr_status_t status,
   output logic         irq
);
   ptmr_status_t st_q;
   logic         armed_q;
   logic         irq_q;
   logic         want;
   logic         fire;

   assign want = (cmp_hit && ie_cmp) || (roll_hit && ie_roll);
   assign fire = want && (repeat_en || armed_q);

   always_ff @(posedge clk) begin
      if (!rst_n || ctrl_wr) begin
         st_q <= '0;
      end else begin
         st_q.cmp  <= cmp_hit  || (st_q.cmp  && !ctrl_rd);
         st_q.roll <= roll_hit || (st_q.roll && !ctrl_rd);
         st_q.any  <= st_q.any || cmp_hit || roll_hit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= fire;
         if (ctrl_wr) begin
            armed_q <= 1'b1;
         end else if (fire) begin
            armed_q <= 1'b0;
         end
      end
   end

   assign status = st_q;
   assign irq    = irq_q;

endmodule

// File: rtl/prog_timer16.sv
module prog_timer16
   import ptmr_pkg::*;
#(
   parameter int unsigned CW       = 16,
   parameter int unsigned UNIT_IDX = 2,
   parameter int unsigned PRE_DIV  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [1:0]    reg_addr,
   input  logic [CW-1:0] reg_wdata,
   output logic [CW-1:0] reg_rdata,
   input  logic          pix_tick,
   input  logic          line_tick,
   output logic          irq
);
   if (CW < 13) begin : g_bad_cw
      $error("prog_timer16: CW must hold the status bits (>= 13)");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [CW-1:0]     cmp_q;
   logic [CW-1:0]     cnt_q;
   logic              ctrl_wr;
   logic              ctrl_rd;
   logic              cnt_wr;
   logic              cmp_wr;
   logic              tick;
   logic              cmp_hit;
   logic              roll_hit;
   ptmr_status_t      status;
   logic [CW-1:0]     ctrl_view;

   assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
   assign cnt_wr  = reg_wr && (reg_addr == ADDR_COUNT);
   assign cmp_wr  = reg_wr && (reg_addr == ADDR_CMP);
   assign ctrl_rd = reg_rd && (reg_addr == ADDR_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cmp_q  <= '0;
      end else begin
         if (ctrl_wr) ctrl_q <= reg_wdata[CTRL_W-1:0];
         if (cmp_wr)  cmp_q  <= reg_wdata;
      end
   end

   ptmr_tick_sel #(
      .UNIT_IDX (UNIT_IDX),
      .PRE_DIV  (PRE_DIV)
   ) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (ctrl_wr),
      .halt      (ctrl_q[B_HALT]),
      .src_ext   (ctrl_q[B_SRC_EXT]),
      .src_div   (ctrl_q[B_SRC_DIV]),
      .pix_tick  (pix_tick),
      .line_tick (line_tick),
      .tick      (tick)
   );

   ptmr_count_core #(
      .CW (CW)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (ctrl_wr),
      .load     (cnt_wr),
      .load_val (reg_wdata),
      .tick     (tick),
      .wrap_cmp (ctrl_q[B_WRAP_CMP]),
      .cmp_val  (cmp_q),
      .count    (cnt_q),
      .cmp_hit  (cmp_hit),
      .roll_hit (roll_hit)
   );

   ptmr_event_ctl u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (ctrl_wr),
      .ctrl_rd   (ctrl_rd),
      .cmp_hit   (cmp_hit),
      .roll_hit  (roll_hit),
      .ie_cmp    (ctrl_q[B_IE_CMP]),
      .ie_roll   (ctrl_q[B_IE_ROLL]),
      .repeat_en (ctrl_q[B_REPEAT]),
      .status    (status),
      .irq       (irq)
   );

   always_comb begin
      ctrl_view                 = '0;
      ctrl_view[CTRL_W-1:0]     = ctrl_q;
      ctrl_view[B_ST_ANY]       = status.any;
      ctrl_view[B_ST_CMP]       = status.cmp;
      ctrl_view[B_ST_ROLL]      = status.roll;
   end

   always_comb begin
      unique case (reg_addr)
         ADDR_COUNT: reg_rdata = cnt_q;
         ADDR_CTRL:  reg_rdata = ctrl_view;
         ADDR_CMP:   reg_rdata = cmp_q;
         default:    reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/prog_timer16_chk.sv
module prog_timer16_chk #(
   parameter int unsigned CW       = 16,
   parameter int unsigned UNIT_IDX = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic          reg_rd,
   input logic [1:0]    reg_addr,
   input logic [CW-1:0] reg_rdata,
   input logic [CW-1:0] cnt_q,
   input logic [9:0]    ctrl_q,
   input logic          st_roll,
   input logic          irq
);
   logic ctrl_wr_c;
   logic ctrl_rd_c;
   assign ctrl_wr_c = reg_wr && (reg_addr == 2'd1);
   assign ctrl_rd_c = reg_rd && (reg_addr == 2'd1);

   assert_ctrl_wr_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr_c |=> (cnt_q == '0));

   assert_cmp_wr_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd2) |=>
         (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

   assert_top_bits_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd1) |-> ((reg_rdata >> 13) == '0));

   assert_single_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ctrl_q[6]) |=> !irq);

   assert_halt_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (UNIT_IDX == 2 && ctrl_q[0] && !reg_wr) |=> $stable(cnt_q));

   assert_roll_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_roll && !ctrl_rd_c && !ctrl_wr_c) |=> st_roll);

endmodule

bind prog_timer16 prog_timer16_chk #(
   .CW       (CW),
   .UNIT_IDX (UNIT_IDX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .cnt_q     (cnt_q),
   .ctrl_q    (ctrl_q),
   .st_roll   (status.roll),
   .irq       (irq)
);

// File: tb/prog_timer16_tb.sv
module prog_timer16_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] rdata_main, rdata_line, rdata_pix;
   logic        irq_main, irq_line, irq_pix;
   logic        pix_tick = 1'b0;
   logic        line_tick = 1'b0;

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prog_timer16 #(.UNIT_IDX(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_main),
      .pix_tick(pix_tick), .line_tick(line_tick), .irq(irq_main));

   prog_timer16 #(.UNIT_IDX(1)) u_dut_line (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_line),
      .pix_tick(pix_tick), .line_tick(line_tick), .irq(irq_line));

   prog_timer16 #(.UNIT_IDX(0)) u_dut_pix (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_pix),
      .pix_tick(pix_tick), .line_tick(line_tick), .irq(irq_pix));

   always @(posedge clk) if (irq_main) irq_cnt <= irq_cnt + 1;

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [1:0] a, logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic peek(logic [1:0] a, output logic [15:0] v);
      reg_addr = a;
      #1 v = rdata_main;
   endtask

   task automatic read_ctrl(output logic [15:0] v);
      reg_addr = 2'd1; reg_rd = 1'b1;
      #1 v = rdata_main;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic t_reset;
      logic [15:0] v;
      peek(2'd0, v); check("R1 count", v, 16'h0);
      peek(2'd1, v); check("R1 ctrl", v, 16'h0);
      peek(2'd2, v); check("R1 cmp", v, 16'h0);
      check("R1 irq", {15'b0, irq_main}, 16'h0);
   endtask

   task automatic t_free_run;
      logic [15:0] v;
      bus_wr(2'd1, 16'h0000);
      repeat (5) @(negedge clk);
      peek(2'd0, v); check("R2 free count", v, 16'd5);
      bus_wr(2'd0, 16'h1234);
      peek(2'd0, v); check("R2 load", v, 16'h1234);
      repeat (2) @(negedge clk);
      peek(2'd0, v); check("R2 after load", v, 16'h1236);
   endtask

   task automatic t_cmp_write;
      logic [15:0] v;
      bus_wr(2'd1, 16'h0000);
      repeat (5) @(negedge clk);
      bus_wr(2'd2, 16'd3);
      peek(2'd0, v); check("R8 cmp write keeps count", v, 16'd6);
      bus_wr(2'd1, 16'h0000);
      peek(2'd0, v); check("R8 ctrl write zeroes", v, 16'd0);
   endtask

   task automatic t_wrap_cmp;
      logic [15:0] v;
      bus_wr(2'd2, 16'd4);
      bus_wr(2'd1, 16'h0008);
      repeat (7) @(negedge clk);
      peek(2'd0, v); check("R3 wrap at 7", v, 16'd2);
      repeat (3) @(negedge clk);
      peek(2'd0, v); check("R3 wrap at 10", v, 16'd0);
   endtask

   task automatic t_repeat_irq;
      int base;
      bus_wr(2'd2, 16'd3);
      bus_wr(2'd1, 16'h0058);
      base = irq_cnt;
      repeat (14) @(negedge clk);
      check("R5 repeat pulses", 16'(irq_cnt - base), 16'd3);
   endtask

   task automatic t_one_shot;
      int base;
      bus_wr(2'd1, 16'h0018);
      base = irq_cnt;
      repeat (14) @(negedge clk);
      check("R6 single pulse", 16'(irq_cnt - base), 16'd1);
      bus_wr(2'd1, 16'h0018);
      base = irq_cnt;
      repeat (6) @(negedge clk);
      check("R6 rearm", 16'(irq_cnt - base), 16'd1);
   endtask

   task automatic t_rollover;
      logic [15:0] v;
      int base;
      bus_wr(2'd2, 16'h8000);
      bus_wr(2'd1, 16'h0020);
      bus_wr(2'd0, 16'hFFFD);
      base = irq_cnt;
      repeat (3) @(negedge clk);
      peek(2'd0, v); check("R4 rolled to zero", v, 16'd0);
      repeat (2) @(negedge clk);
      check("R4 rollover irq", 16'(irq_cnt - base), 16'd1);
      read_ctrl(v); check("R7 flags set", v, 16'h1420);
      read_ctrl(v); check("R7 flags cleared", v, 16'h0420);
   endtask

   task automatic t_prescale;
      logic [15:0] v;
      bus_wr(2'd1, 16'h0200);
      repeat (15) @(negedge clk);
      peek(2'd0, v); check("R9 div at 15", v, 16'd1);
      @(negedge clk);
      peek(2'd0, v); check("R9 div at 16", v, 16'd2);
   endtask

   task automatic t_halt;
      logic [15:0] v;
      bus_wr(2'd1, 16'h0001);
      repeat (10) @(negedge clk);
      peek(2'd0, v); check("R9 halted", v, 16'd0);
      bus_wr(2'd0, 16'd5);
      repeat (4) @(negedge clk);
      peek(2'd0, v); check("R9 halted after load", v, 16'd5);
   endtask

   task automatic t_reserved;
      logic [15:0] v;
      bus_wr(2'd1, 16'hFC01);
      read_ctrl(v); check("R10 upper bits", v, 16'h0001);
   endtask

   task automatic t_ext_src;
      logic [15:0] v;
      bus_wr(2'd1, 16'h0100);
      line_tick = 1'b1; pix_tick = 1'b1;
      repeat (2) @(negedge clk);
      pix_tick = 1'b0;
      @(negedge clk);
      line_tick = 1'b0;
      repeat (4) @(negedge clk);
      reg_addr = 2'd0;
      #1;
      check("R11 line copy", rdata_line, 16'd3);
      check("R11 pixel copy", rdata_pix, 16'd2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_free_run();
      t_cmp_write();
      t_wrap_cmp();
      t_repeat_irq();
      t_one_shot();
      t_rollover();
      t_prescale();
      t_halt();
      t_reserved();
      t_ext_src();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule